// File: doc/BRIEF.md
# Boundary-Scan Pad Cell Chain

This block is the boundary-scan data register that sits between the core and a group of IO pads. It supports four kinds of IO. An input-only IO has one scan cell. An output-only IO has one. A tri-state output has two, one for the value and one for the enable. A bidirectional IO has three: input, output and enable. All cells are joined into a single serial chain between `tdi` and `tdo`.

A separate test-access controller owns the state machine. It supplies:
- the instruction code, with a strobe that loads it;
- the capture, shift and update strobes for the data register;
- a test-logic-reset pulse.

In functional mode every signal passes straight through, pad to core and core to pad. Under sample/preload the chain captures live pin and core values and loads new values into the update latches, and the pins are not disturbed. Under external test the pad outputs and enables are driven from the update latches, and the core sees its input values from the latches as well.

Each of the four IO counts is a parameter and must be at least 1. The chain length is the derived value `CHAIN_LEN = N_IN + N_OUT + 2*N_TRI + 3*N_BIDIR`, which is 7 with the defaults.

Top module: `bsc_chain`

## Requirements
- R1: Cell positions run from cell 0 (next to `tdo`) upward, in this order: input IOs (pad input each), output IOs (core output each), tri-state IOs (value, then enable, per IO), bidirectional IOs (pad input, core output, core enable, per IO). With one IO of each kind the cells are 0 in, 1 out, 2 tri value, 3 tri enable, 4 bidir in, 5 bidir out, 6 bidir enable.
- R2: When external test is not the active mode, every pad output and enable equals its core value and every core input equals its pad input. This includes the state after reset.
- R3: The mode is taken from `ir_code` on a cycle with `ir_update` high. Code 0 selects external test, code 2 selects sample/preload, and any other code deselects the chain. While the chain is deselected, capture, shift and update strobes have no effect.
- R4: A capture strobe while the chain is selected loads every cell with the value given in R1, taken from the pins and core of that cycle. Capture has priority over shift and update.
- R5: A shift strobe while the chain is selected moves each cell one place toward `tdo`. Cell CHAIN_LEN-1 takes `tdi`, and `tdo` always shows cell 0. The first bit shifted in therefore ends in cell 0 after CHAIN_LEN shifts.
- R6: The update latches copy the chain only on an update strobe while the chain is selected and neither capture nor shift is asserted. At all other times they hold.
- R7: Under external test, each pad output and enable takes its latch bit, and the core input of each input and bidirectional IO takes its latch bit instead of the pad.
- R8: Values preloaded under sample/preload leave the pins unchanged, and they appear on the pads as soon as external test is selected, with no further scan.
- R9: A test-logic-reset pulse returns the mode to functional pass-through from the next cycle. The update latches keep their contents.
- R10: After `rst_n` is released, `tdo` is 0, the chain and latches are all zero, and the mode is functional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | Test-logic-reset pulse from the controller |
| ir_update | input | 1 | Strobe that loads `ir_code` into the mode |
| ir_code | input | IR_W | Instruction code |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (cell 0) |
| in_pad_i | input | N_IN | Input IO pad values |
| in_core_i | output | N_IN | Input IO values seen by core |
| out_core_o | input | N_OUT | Output IO core values |
| out_pad_o | output | N_OUT | Output IO pad drive |
| tri_core_o | input | N_TRI | Tri-state core values |
| tri_core_oe | input | N_TRI | Tri-state core enables |
| tri_pad_o | output | N_TRI | Tri-state pad values |
| tri_pad_oe | output | N_TRI | Tri-state pad enables |
| bd_pad_i | input | N_BIDIR | Bidirectional pad input |
| bd_core_i | output | N_BIDIR | Bidirectional input seen by core |
| bd_core_o | input | N_BIDIR | Bidirectional core output |
| bd_core_oe | input | N_BIDIR | Bidirectional core enable |
| bd_pad_o | output | N_BIDIR | Bidirectional pad output |
| bd_pad_oe | output | N_BIDIR | Bidirectional pad enable |

## Verification
The hardest case to reach from the ports is a set of latch contents that were written in one mode and then become visible in another. Examples are a preload under sample/preload that shows up only when external test is selected, an update strobed while the chain is deselected, and latches that survive a test-logic reset. The stimulus reaches these with directed sequences. Each one scans a known vector, changes the instruction without scanning again, and compares the pads with the last vector a valid update could have stored. These sequences are mixed with seeded random scans under both selecting codes, which use random pin and core values.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [1:0] {
        BSM_FUNC   = 2'd0,
        BSM_SAMPLE = 2'd1,
        BSM_EXTEST = 2'd2
    } bsc_mode_e;

    localparam int unsigned CODE_EXTEST = 0;
    localparam int unsigned CODE_SAMPLE = 2;

    function automatic int unsigned chain_len(input int unsigned n_in,
                                              input int unsigned n_out,
                                              input int unsigned n_tri,
                                              input int unsigned n_bd);
        return n_in + n_out + 2 * n_tri + 3 * n_bd;
    endfunction

endpackage

// File: rtl/bsc_mode_reg.sv
module bsc_mode_reg
    import bsc_pkg::*;
#(
    parameter int unsigned IR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tlr,
    input  logic            ir_update,
    input  logic [IR_W-1:0] ir_code,
    output logic            sel,
    output logic            ext
);

    typedef struct packed {
        bsc_mode_e mode;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tlr) begin
            st_d.mode = BSM_FUNC;
        end else if (ir_update) begin
            if (ir_code == IR_W'(CODE_EXTEST))
                st_d.mode = BSM_EXTEST;
            else if (ir_code == IR_W'(CODE_SAMPLE))
                st_d.mode = BSM_SAMPLE;
            else
                st_d.mode = BSM_FUNC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{mode: BSM_FUNC};
        else
            st_q <= st_d;
    end

    assign sel = (st_q.mode != BSM_FUNC);
    assign ext = (st_q.mode == BSM_EXTEST);

endmodule

// File: rtl/bsc_shift_stage.sv
module bsc_shift_stage #(
    parameter int unsigned LEN = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           capture_dr,
    input  logic           shift_dr,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] chain,
    output logic           tdo
);

    logic [LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (sel && capture_dr)
            chain_d = cap_vec;
        else if (sel && shift_dr)
            chain_d = {tdi, chain_q[LEN-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= chain_d;
    end

    assign chain = chain_q;
    assign tdo   = chain_q[0];

endmodule

// File: rtl/bsc_update_stage.sv
module bsc_update_stage #(
    parameter int unsigned LEN = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           capture_dr,
    input  logic           shift_dr,
    input  logic           update_dr,
    input  logic [LEN-1:0] chain,
    output logic [LEN-1:0] upd
);

    logic [LEN-1:0] upd_d, upd_q;
    logic           take;

    always_comb begin
        take  = sel && update_dr && !capture_dr && !shift_dr;
        upd_d = take ? chain : upd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            upd_q <= '0;
        else
            upd_q <= upd_d;
    end

    assign upd = upd_q;

endmodule

// File: rtl/bsc_pad_map.sv
module bsc_pad_map #(
    parameter int unsigned N_IN    = 1,
    parameter int unsigned N_OUT   = 1,
    parameter int unsigned N_TRI   = 1,
    parameter int unsigned N_BIDIR = 1,
    parameter int unsigned LEN     = 7
) (
    input  logic               ext,
    input  logic [LEN-1:0]     upd,
    output logic [LEN-1:0]     cap_vec,
    input  logic [N_IN-1:0]    in_pad_i,
    output logic [N_IN-1:0]    in_core_i,
    input  logic [N_OUT-1:0]   out_core_o,
    output logic [N_OUT-1:0]   out_pad_o,
    input  logic [N_TRI-1:0]   tri_core_o,
    input  logic [N_TRI-1:0]   tri_core_oe,
    output logic [N_TRI-1:0]   tri_pad_o,
    output logic [N_TRI-1:0]   tri_pad_oe,
    input  logic [N_BIDIR-1:0] bd_pad_i,
    output logic [N_BIDIR-1:0] bd_core_i,
    input  logic [N_BIDIR-1:0] bd_core_o,
    input  logic [N_BIDIR-1:0] bd_core_oe,
    output logic [N_BIDIR-1:0] bd_pad_o,
    output logic [N_BIDIR-1:0] bd_pad_oe
);

    localparam int unsigned BASE_OUT = N_IN;
    localparam int unsigned BASE_TRI = BASE_OUT + N_OUT;
    localparam int unsigned BASE_BD  = BASE_TRI + 2 * N_TRI;

    for (genvar g = 0; g < N_IN; g++) begin : g_in
        assign cap_vec[g]   = in_pad_i[g];
        assign in_core_i[g] = ext ? upd[g] : in_pad_i[g];
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        assign cap_vec[BASE_OUT+g] = out_core_o[g];
        assign out_pad_o[g]        = ext ? upd[BASE_OUT+g] : out_core_o[g];
    end

    for (genvar g = 0; g < N_TRI; g++) begin : g_tri
        localparam int unsigned C = BASE_TRI + 2 * g;
        assign cap_vec[C]     = tri_core_o[g];
        assign cap_vec[C+1]   = tri_core_oe[g];
        assign tri_pad_o[g]   = ext ? upd[C]   : tri_core_o[g];
        assign tri_pad_oe[g]  = ext ? upd[C+1] : tri_core_oe[g];
    end

    for (genvar g = 0; g < N_BIDIR; g++) begin : g_bd
        localparam int unsigned C = BASE_BD + 3 * g;
        assign cap_vec[C]    = bd_pad_i[g];
        assign cap_vec[C+1]  = bd_core_o[g];
        assign cap_vec[C+2]  = bd_core_oe[g];
        assign bd_core_i[g]  = ext ? upd[C]   : bd_pad_i[g];
        assign bd_pad_o[g]   = ext ? upd[C+1] : bd_core_o[g];
        assign bd_pad_oe[g]  = ext ? upd[C+2] : bd_core_oe[g];
    end

endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
    import bsc_pkg::*;
#(
    parameter int unsigned IR_W    = 4,
    parameter int unsigned N_IN    = 1,
    parameter int unsigned N_OUT   = 1,
    parameter int unsigned N_TRI   = 1,
    parameter int unsigned N_BIDIR = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tlr,
    input  logic               ir_update,
    input  logic [IR_W-1:0]    ir_code,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    output logic               tdo,
    input  logic [N_IN-1:0]    in_pad_i,
    output logic [N_IN-1:0]    in_core_i,
    input  logic [N_OUT-1:0]   out_core_o,
    output logic [N_OUT-1:0]   out_pad_o,
    input  logic [N_TRI-1:0]   tri_core_o,
    input  logic [N_TRI-1:0]   tri_core_oe,
    output logic [N_TRI-1:0]   tri_pad_o,
    output logic [N_TRI-1:0]   tri_pad_oe,
    input  logic [N_BIDIR-1:0] bd_pad_i,
    output logic [N_BIDIR-1:0] bd_core_i,
    input  logic [N_BIDIR-1:0] bd_core_o,
    input  logic [N_BIDIR-1:0] bd_core_oe,
    output logic [N_BIDIR-1:0] bd_pad_o,
    output logic [N_BIDIR-1:0] bd_pad_oe
);

    localparam int unsigned CHAIN_LEN = chain_len(N_IN, N_OUT, N_TRI, N_BIDIR);

    logic                 sel;
    logic                 ext;
    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] chain_q;
    logic [CHAIN_LEN-1:0] upd_q;

    bsc_mode_reg #(.IR_W(IR_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .tlr       (tlr),
        .ir_update (ir_update),
        .ir_code   (ir_code),
        .sel       (sel),
        .ext       (ext)
    );

    bsc_shift_stage #(.LEN(CHAIN_LEN)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .cap_vec    (cap_vec),
        .chain      (chain_q),
        .tdo        (tdo)
    );

    bsc_update_stage #(.LEN(CHAIN_LEN)) u_upd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .chain      (chain_q),
        .upd        (upd_q)
    );

    bsc_pad_map #(
        .N_IN(N_IN), .N_OUT(N_OUT), .N_TRI(N_TRI), .N_BIDIR(N_BIDIR), .LEN(CHAIN_LEN)
    ) u_map (
        .ext         (ext),
        .upd         (upd_q),
        .cap_vec     (cap_vec),
        .in_pad_i    (in_pad_i),
        .in_core_i   (in_core_i),
        .out_core_o  (out_core_o),
        .out_pad_o   (out_pad_o),
        .tri_core_o  (tri_core_o),
        .tri_core_oe (tri_core_oe),
        .tri_pad_o   (tri_pad_o),
        .tri_pad_oe  (tri_pad_oe),
        .bd_pad_i    (bd_pad_i),
        .bd_core_i   (bd_core_i),
        .bd_core_o   (bd_core_o),
        .bd_core_oe  (bd_core_oe),
        .bd_pad_o    (bd_pad_o),
        .bd_pad_oe   (bd_pad_oe)
    );

endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk #(
    parameter int unsigned LEN   = 7,
    parameter int unsigned N_IN  = 1,
    parameter int unsigned N_OUT = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tlr,
    input logic             tdi,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             sel,
    input logic             ext,
    input logic [LEN-1:0]   chain_q,
    input logic [LEN-1:0]   upd_q,
    input logic [N_IN-1:0]  in_pad_i,
    input logic [N_IN-1:0]  in_core_i,
    input logic [N_OUT-1:0] out_core_o,
    input logic [N_OUT-1:0] out_pad_o
);

    p_shift_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift_dr && !capture_dr) |=> (chain_q[LEN-1] == $past(tdi)));

    p_shift_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift_dr && !capture_dr) |=> (chain_q[LEN-2:0] == $past(chain_q[LEN-1:1])));

    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && update_dr && !capture_dr && !shift_dr) |=> $stable(upd_q));

    p_unsel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(chain_q));

    p_tlr_func_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tlr |=> !ext);

    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ext |-> (in_core_i == in_pad_i && out_pad_o == out_core_o));

    p_extest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext |-> (in_core_i == upd_q[N_IN-1:0]));

endmodule

bind bsc_chain bsc_chain_chk #(.LEN(CHAIN_LEN), .N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tlr        (tlr),
    .tdi        (tdi),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .sel        (sel),
    .ext        (ext),
    .chain_q    (chain_q),
    .upd_q      (upd_q),
    .in_pad_i   (in_pad_i),
    .in_core_i  (in_core_i),
    .out_core_o (out_core_o),
    .out_pad_o  (out_pad_o)
);

// File: tb/tb_bsc_chain.sv
module tb_bsc_chain;

    localparam int CLK_PERIOD = 10;
    localparam int L = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tlr = 1'b0, ir_update = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic [3:0] ir_code = 4'd15;
    logic tdo;
    logic [0:0] in_pad_i = '0, in_core_i, out_core_o = '0, out_pad_o;
    logic [0:0] tri_core_o = '0, tri_core_oe = '0, tri_pad_o, tri_pad_oe;
    logic [0:0] bd_pad_i = '0, bd_core_i, bd_core_o = '0, bd_core_oe = '0, bd_pad_o, bd_pad_oe;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsc_chain dut (.*);

    logic [L-1:0] m_latch;
    bit           m_ext;

    function automatic logic [L-1:0] cap_model();
        return {bd_core_oe[0], bd_core_o[0], bd_pad_i[0], tri_core_oe[0], tri_core_o[0],
                out_core_o[0], in_pad_i[0]};
    endfunction

    function automatic logic [L-1:0] pad_view();
        return {bd_pad_oe[0], bd_pad_o[0], bd_core_i[0], tri_pad_oe[0], tri_pad_o[0],
                out_pad_o[0], in_core_i[0]};
    endfunction

    task automatic check(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_pads(input string req);
        check(req, pad_view(), m_ext ? m_latch : cap_model());
    endtask

    task automatic load_ir(input logic [3:0] code);
        ir_code = code; ir_update = 1'b1;
        @(negedge clk);
        ir_update = 1'b0;
        if (code == 4'd0) m_ext = 1; else m_ext = 0;
    endtask

    task automatic set_pins(input logic [4:0] v);
        {bd_pad_i[0], tri_core_oe[0], tri_core_o[0], out_core_o[0], in_pad_i[0]} = v;
        bd_core_o[0] = v[0] ^ v[3];
        bd_core_oe[0] = v[1] ^ v[4];
    endtask

    task automatic scan(input logic [L-1:0] din, output logic [L-1:0] dout);
        capture_dr = 1'b1;
        @(negedge clk);
        capture_dr = 1'b0;
        for (int i = 0; i < L; i++) begin
            shift_dr = 1'b1; tdi = din[i];
            dout[i] = tdo;
            @(negedge clk);
        end
        shift_dr = 1'b0;
        update_dr = 1'b1;
        @(negedge clk);
        update_dr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] got, vec, prev_vec;
        void'($urandom(32'h5eed_0b5c));
        m_latch = '0; m_ext = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R2 pass-through after reset
        check("R10 tdo after reset", {6'b0, tdo}, '0);
        set_pins(5'b10110);
        #1 check_pads("R2 functional after reset");

        // R4/R1 capture ordering, R8 preload not disturbing pins
        load_ir(4'd2);
        set_pins(5'b01101);
        vec = 7'b1010011;
        scan(vec, got);
        check("R4 R1 capture under sample", got, cap_model());
        m_latch = vec;
        check_pads("R8 pins untouched after preload");
        // R8 preload appears on extest
        load_ir(4'd0);
        check_pads("R8 preload visible on extest");
        check("R7 extest drives latch", pad_view(), 7'b1010011);

        // R5 shift path: captured bit 0 first, shifted vector round trip
        prev_vec = vec;
        vec = 7'b0110100;
        scan(vec, got);
        check("R5 R4 capture under extest", got, cap_model());
        m_latch = vec;
        check_pads("R7 R6 new latch after update");

        // R5: rescan returns what was shifted when capture reproduces it? use tdo ordering
        // R6: shift without update leaves pads
        capture_dr = 1'b1; @(negedge clk); capture_dr = 1'b0;
        for (int i = 0; i < L; i++) begin
            shift_dr = 1'b1; tdi = ~vec[i]; @(negedge clk);
        end
        shift_dr = 1'b0;
        check_pads("R6 no update no pad change");
        check("R5 tdo shows first shifted bit", {6'b0, tdo}, {6'b0, ~vec[0]});

        // R9 test-logic reset
        tlr = 1'b1; @(negedge clk); tlr = 1'b0;
        m_ext = 0;
        check_pads("R9 functional after tlr");
        load_ir(4'd0);
        check_pads("R9 latch retained through tlr");

        // R3 deselected code ignores capture/shift/update
        prev_vec = m_latch;
        load_ir(4'd1);
        check_pads("R3 functional under other code");
        scan(7'b1111111, got);
        check("R3 chain frozen when deselected", got, {L{~vec[0]}});
        load_ir(4'd0);
        check("R3 update ignored when deselected", pad_view(), prev_vec);

        // random mix under codes 0 and 2
        for (int n = 0; n < 40; n++) begin
            logic [L-1:0] exp_cap;
            load_ir(($urandom % 2) ? 4'd2 : 4'd0);
            set_pins(5'($urandom));
            #1 check_pads("R2 R7 mode view random");
            exp_cap = cap_model();
            vec = L'($urandom);
            scan(vec, got);
            check("R4 random capture", got, exp_cap);
            m_latch = vec;
            check_pads("R6 R8 random after update");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule